// File: doc/BRIEF.md
# Output Data Rate and Sync Generator

This block paces the sample output of a sensor. It issues a one-cycle sample strobe at the selected output data rate and keeps a data-ready flag that a status read clears. It also drives an interrupt pin whose active level can be programmed. The pace comes from one of two sources. The first is an internal table that divides a 24 kHz base tick enable by a per-code factor. The second is an external synchronization pin: after a two-flop synchronizer, its active edges are counted and divided.

Rate code, sync mode and divider are inputs of the block and are held stable by the surrounding logic. A change to any of them restarts both counters, so the first strobe at the new setting follows a full new period. The sync-edge polarity and the interrupt polarity can change at any time without restarting anything.

Top module: `odr_sync_gen`

## Requirements
- R1: While reset is active, and right after it is released, `smp_stb` is 0 and `drdy` is 0, so `irq_pin` sits at its inactive level: 1 when `drdy_pol` is 0.
- R2: With `sync_mode` 0, the strobe fires on every Nth base tick. N is 12, 24, 48, 96, 192, 384, 4, 2 for rate codes 0 to 7, which gives 2000, 1000, 500, 250, 125, 62.5, 6000 and 12000 Hz from 24 kHz. The strobe rises in the cycle after the completing tick is sampled and lasts one cycle.
- R3: `sync_mode` 0 selects the internal tick source and ignores sync pin edges. `sync_mode` 1 selects the external sync pin and ignores base ticks.
- R4: `sync_pol` 1 makes a rising edge of `sync_pin` active and `sync_pol` 0 makes a falling edge active. The pin goes through two flops and an edge register, so a strobe caused by an edge appears three cycles after the new pin level is first sampled.
- R5: In external mode a strobe fires on every 2×(`sync_div`+1)th active edge. A divider of 0 therefore gives one strobe per two active edges, which is half the sync frequency.
- R6: A change of `rate_code`, `sync_mode` or `sync_div` clears both counters in the next cycle. No strobe fires in the cycle after the change, and the next strobe needs a full period at the new setting.
- R7: `drdy` becomes 1 in the cycle after a strobe. It becomes 0 in the cycle after `stat_ack` when no strobe is present, and otherwise holds its value. When the strobe and `stat_ack` coincide, the set wins.
- R8: `irq_pin` equals `drdy` when `drdy_pol` is 1 and its inverse when `drdy_pol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| base_tick | input | 1 | 24 kHz base tick enable, one cycle per tick |
| sync_pin | input | 1 | Raw external synchronization input |
| rate_code | input | 3 | Internal rate selection |
| sync_pol | input | 1 | Active sync edge: 1 rising, 0 falling |
| sync_mode | input | 1 | Rate source: 0 internal, 1 external |
| sync_div | input | 16 | External divider value |
| drdy_pol | input | 1 | Interrupt active level: 1 high, 0 low |
| stat_ack | input | 1 | Status-read acknowledge, clears data ready |
| smp_stb | output | 1 | One-cycle sample strobe |
| drdy | output | 1 | Data-ready level for the status register |
| irq_pin | output | 1 | Polarity-adjusted interrupt pin |

## Verification
Two situations are hard to reach from the ports: a restart in the middle of a period, and a status acknowledge that lands in the same cycle as a strobe. For the first, the bench stops a slow rate code part way through its count and switches to another code. Its model then expects the first strobe only after a complete new period. For the second, the bench lines up the acknowledge with the cycle in which the strobe is visible, using a code that divides by two. It also checks external edges under both polarities with a divider of zero, and checks that each source ignores the other's stimulus.

// File: rtl/odr_pkg.sv
package odr_pkg;
  localparam int TICK_CNT_W = 9;
  localparam int SYNC_DIV_W = 16;

  function automatic logic [TICK_CNT_W-1:0] rate_ticks(input logic [2:0] code);
    logic [TICK_CNT_W-1:0] n;
    case (code)
      3'd0:    n = TICK_CNT_W'(12);
      3'd1:    n = TICK_CNT_W'(24);
      3'd2:    n = TICK_CNT_W'(48);
      3'd3:    n = TICK_CNT_W'(96);
      3'd4:    n = TICK_CNT_W'(192);
      3'd5:    n = TICK_CNT_W'(384);
      3'd6:    n = TICK_CNT_W'(4);
      default: n = TICK_CNT_W'(2);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/odr_rst_sync.sv
module odr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/odr_sync_in.sv
module odr_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_act,
  output logic act_edge
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d[0] = pin;
    for (int i = 1; i <= STAGES; i++) sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  logic cur, prev;
  assign cur  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];

  generate
    if (STAGES >= 2) begin : g_edge
      assign act_edge = rise_act ? (cur & ~prev) : (~cur & prev);
    end else begin : g_edge_min
      assign act_edge = rise_act ? (cur & ~prev) : (~cur & prev);
    end
  endgenerate

  assert_edge_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_edge |=> !act_edge);
endmodule

// File: rtl/odr_rate_div.sv
module odr_rate_div
  import odr_pkg::*;
#(
  parameter int DIV_W = SYNC_DIV_W,
  parameter int TCW   = TICK_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [2:0]       rate_code,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] ext_div,
  input  logic             act_edge,
  output logic             strobe
);
  localparam int ECW   = DIV_W + 1;
  localparam int CFG_W = 3 + 1 + DIV_W;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [TCW-1:0]   cnt_q, cnt_d, lim;
  logic [ECW-1:0]   ecnt_q, ecnt_d, elim;
  logic             stb_q, stb_d;
  logic             restart, int_last, ext_last;

  assign cfg_d    = {rate_code, ext_mode, ext_div};
  assign restart  = (cfg_d != cfg_q);
  assign lim      = rate_ticks(rate_code);
  assign elim     = {ext_div, 1'b1};
  assign int_last = (cnt_q == lim - 1'b1);
  assign ext_last = (ecnt_q == elim);

  always_comb begin
    cnt_d  = cnt_q;
    ecnt_d = ecnt_q;
    stb_d  = 1'b0;
    if (restart) begin
      cnt_d  = '0;
      ecnt_d = '0;
    end else if (!ext_mode) begin
      if (tick_en) begin
        if (int_last) begin
          cnt_d = '0;
          stb_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      if (act_edge) begin
        if (ext_last) begin
          ecnt_d = '0;
          stb_d  = 1'b1;
        end else begin
          ecnt_d = ecnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      ecnt_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cnt_q  <= cnt_d;
      ecnt_q <= ecnt_d;
      stb_q  <= stb_d;
    end
  end

  assign strobe = stb_q;

  assert_restart_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !strobe);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !ext_mode) |-> (cnt_q < lim));
  assert_ecnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && ext_mode) |-> (ecnt_q <= elim));
  assert_tick_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !restart && !act_edge) |=> !strobe);
endmodule

// File: rtl/odr_drdy.sv
module odr_drdy (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic ack,
  input  logic pol,
  output logic drdy,
  output logic pin
);
  logic rdy_q, rdy_d;

  always_comb begin
    rdy_d = rdy_q;
    if (strobe)   rdy_d = 1'b1;
    else if (ack) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_d;
  end

  assign drdy = rdy_q;
  assign pin  = pol ? rdy_q : ~rdy_q;

  assert_drdy_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> drdy);
  assert_drdy_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !strobe) |=> !drdy);
  assert_drdy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !strobe) |=> $stable(drdy));
endmodule

// File: rtl/odr_sync_gen.sv
module odr_sync_gen
  import odr_pkg::*;
#(
  parameter int DIV_W       = SYNC_DIV_W,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             base_tick,
  input  logic             sync_pin,
  input  logic [2:0]       rate_code,
  input  logic             sync_pol,
  input  logic             sync_mode,
  input  logic [DIV_W-1:0] sync_div,
  input  logic             drdy_pol,
  input  logic             stat_ack,
  output logic             smp_stb,
  output logic             drdy,
  output logic             irq_pin
);
  logic rst_n;
  logic act_edge;
  logic stb;

  odr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk   (clk),
    .arst_n(arst_n),
    .rst_n (rst_n)
  );

  odr_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (sync_pin),
    .rise_act(sync_pol),
    .act_edge(act_edge)
  );

  odr_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (base_tick),
    .rate_code(rate_code),
    .ext_mode (sync_mode),
    .ext_div  (sync_div),
    .act_edge (act_edge),
    .strobe   (stb)
  );

  odr_drdy u_drdy (
    .clk   (clk),
    .rst_n (rst_n),
    .strobe(stb),
    .ack   (stat_ack),
    .pol   (drdy_pol),
    .drdy  (drdy),
    .pin   (irq_pin)
  );

  assign smp_stb = stb;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_n |=> !smp_stb);
endmodule

// File: tb/test_odr_sync_gen.sv
module test_odr_sync_gen;
  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic base_tick = 1'b0, sync_pin = 1'b0, sync_pol = 1'b0, sync_mode = 1'b0;
  logic drdy_pol = 1'b0, stat_ack = 1'b0;
  logic [2:0]  rate_code = 3'd0;
  logic [15:0] sync_div = 16'd0;
  logic smp_stb, drdy, irq_pin;

  always #10 clk = ~clk;

  odr_sync_gen i_odr_sync_gen (
    .clk(clk), .arst_n(arst_n), .base_tick(base_tick), .sync_pin(sync_pin),
    .rate_code(rate_code), .sync_pol(sync_pol), .sync_mode(sync_mode),
    .sync_div(sync_div), .drdy_pol(drdy_pol), .stat_ack(stat_ack),
    .smp_stb(smp_stb), .drdy(drdy), .irq_pin(irq_pin)
  );

  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int exp_q[$];
  int ph = 0;
  int ecount = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int div_of(input logic [2:0] c);
    case (c)
      3'd0: return 12;  3'd1: return 24;  3'd2: return 48;  3'd3: return 96;
      3'd4: return 192; 3'd5: return 384; 3'd6: return 4;   default: return 2;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare every observed strobe with the scoreboard (R2, R3, R5)
  initial begin
    forever begin
      @(negedge clk);
      if (arst_n && smp_stb) begin
        if (exp_q.size() == 0) chk("R3 unexpected strobe", cyc, -1);
        else chk("R2/R5 strobe cycle", cyc, exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] c, input logic m, input logic [15:0] d,
                         input logic sp);
    @(negedge clk);
    if (c != rate_code || m != sync_mode || d != sync_div) begin
      ph = 0;
      ecount = 0;
    end
    rate_code = c; sync_mode = m; sync_div = d; sync_pol = sp;
    idle(3);
  endtask

  task automatic pulse();
    @(negedge clk);
    base_tick = 1'b1;
    if (!sync_mode) begin
      ph++;
      if (ph == div_of(rate_code)) begin
        ph = 0;
        exp_q.push_back(cyc + 1);
      end
    end
    @(negedge clk);
    base_tick = 1'b0;
  endtask

  task automatic toggle();
    @(negedge clk);
    sync_pin = ~sync_pin;
    if (sync_mode && (sync_pin == sync_pol)) begin
      ecount++;
      if (ecount == 2 * (sync_div + 1)) begin
        ecount = 0;
        exp_q.push_back(cyc + 3);
      end
    end
    idle(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1: reset state while reset is held
    chk("R1 strobe in reset", smp_stb, 0);
    chk("R1 drdy in reset", drdy, 0);
    chk("R1 irq_pin in reset", irq_pin, 1);
    arst_n = 1'b1;
    idle(4);
    chk("R1 drdy after release", drdy, 0);
    chk("R1 irq_pin after release", irq_pin, 1);

    // R2: every rate code, two periods each
    for (int c = 0; c < 8; c++) begin
      set_cfg(3'(c), 1'b0, 16'd0, 1'b0);
      for (int k = 0; k < 2 * div_of(3'(c)); k++) pulse();
      idle(2);
      chk("R2 queue drained", exp_q.size(), 0);
    end

    // R6: restart in mid period, first new strobe after a full new period
    set_cfg(3'd0, 1'b0, 16'd0, 1'b0);
    for (int k = 0; k < 7; k++) pulse();
    set_cfg(3'd1, 1'b0, 16'd0, 1'b0);
    for (int k = 0; k < 24; k++) pulse();
    idle(2);
    chk("R6 one strobe after restart", exp_q.size(), 0);

    // R3: sync edges ignored in internal mode
    for (int k = 0; k < 8; k++) toggle();

    // R5, R4: divider 0 with rising edges
    set_cfg(3'd1, 1'b1, 16'd0, 1'b1);
    for (int k = 0; k < 8; k++) toggle();
    // R3: base ticks ignored in external mode
    for (int k = 0; k < 10; k++) pulse();
    // R4, R5: falling edges with divider 2
    set_cfg(3'd1, 1'b1, 16'd2, 1'b0);
    for (int k = 0; k < 24; k++) toggle();
    // R6: divider change mid count restarts the edge count
    for (int k = 0; k < 4; k++) toggle();
    set_cfg(3'd1, 1'b1, 16'd1, 1'b0);
    for (int k = 0; k < 16; k++) toggle();
    idle(4);
    chk("R5 queue drained", exp_q.size(), 0);

    // R7, R8: data ready set, clear and collision
    set_cfg(3'd7, 1'b0, 16'd0, 1'b0);
    @(negedge clk); stat_ack = 1'b1;
    @(negedge clk); stat_ack = 1'b0;
    chk("R7 ack clears drdy", drdy, 0);
    chk("R8 pin inactive low-pol", irq_pin, 1);
    pulse();
    pulse();           // now at the negedge where the strobe is visible
    stat_ack = 1'b1;   // ack collides with the strobe
    @(negedge clk);
    chk("R7 set wins over ack", drdy, 1);
    chk("R8 pin active low", irq_pin, 0);
    drdy_pol = 1'b1;
    #1 chk("R8 pin active high", irq_pin, 1);
    @(negedge clk); stat_ack = 1'b0;
    chk("R7 ack clears drdy", drdy, 0);
    chk("R8 pin inactive high-pol", irq_pin, 0);
    idle(3);
    chk("R7 drdy holds low", drdy, 0);
    chk("R6 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule